// File: doc/BRIEF.md
# DS3/E3 Transmit Bit Source Selector

This block sits in front of the line encoder of a DS3/E3 transmit path. On every transmit clock it chooses the one serial bit that leaves toward the encoder. The bit can come from the local payload stream, from received data (payload loopback), from an external test-pattern generator, or from the framing formatter's overhead bits. The formatter, the test-pattern generator and the line encoder all live outside. They reach this block only as bit streams and as a per-bit flag that marks framing-overhead positions.

Two overrides sit on top of that choice. An external overhead port can replace the chosen bit whenever its enable is high. The one exception is an unframed test pattern, which is never overwritten. An all-ones condition forces every bit to 1, whatever the internal selection is. That condition is either an alarm-indication request or an unframed all-ones request. A loss of transmit clock also raises the alarm-indication request, but only if the clock-loss switch policy is enabled. Because the force acts after the selection, an internal diagnostic loop can keep running while the line carries all ones.

The chosen bit is registered once before it leaves the block. A combinational payload-take strobe tells upstream logic whether the current bit slot consumes a payload bit.

Top module: `t3_tx_bit_select`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets line_bit to 0. This holds even when a force-to-ones request is present.
- R2: line_bit changes only at a rising clock edge. After edge n it shows the result computed from the inputs sampled at edge n, which is one cycle of latency.
- R3: With test mode 2'b00, loopback off, pass-through off and no override, line_bit follows fmt_bit when ovh_slot is 1 and follows pay_bit when ovh_slot is 0.
- R4: With payload loopback on (and no framed pattern), non-overhead slots carry rx_bit. Overhead slots still carry fmt_bit.
- R5: With test mode 2'b01 (framed pattern), non-overhead slots carry pat_bit, even when loopback is on. Overhead slots still carry fmt_bit.
- R6: With pass-through on, ovh_slot has no effect. Every slot carries the payload source: pat_bit in framed pattern mode, otherwise rx_bit under loopback, otherwise pay_bit.
- R7: When toh_en is 1 and test mode bit 1 is 0, line_bit takes toh_bit. This includes pass-through mode.
- R8: When test mode bit 1 is 1 (unframed pattern), line_bit takes pat_bit on every slot. ovh_slot, pass-through, loopback and toh_en have no effect.
- R9: When ais_req is 1, or when clk_lost and clk_lost_switch are both 1, line_bit is 1 regardless of every data input. clk_lost alone, with clk_lost_switch at 0, changes nothing.
- R10: When ua1_req is 1, line_bit is 1 regardless of every data input, including an unframed pattern.
- R11: pay_take equals 1 when pass_thru is 1. Otherwise it equals the inverse of ovh_slot. It is combinational, so it applies in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pay_bit | input | 1 | Local payload bit |
| rx_bit | input | 1 | Received data bit, used by payload loopback |
| pat_bit | input | 1 | Test-pattern generator bit |
| fmt_bit | input | 1 | Formatter bit for overhead positions |
| ovh_slot | input | 1 | Current bit slot is a framing-overhead position |
| loop_pay | input | 1 | Payload loopback enable |
| pass_thru | input | 1 | Send payload with no internal overhead |
| test_mode | input | 2 | 00 off, 01 framed pattern, 1x unframed pattern |
| toh_en | input | 1 | External overhead overwrite enable |
| toh_bit | input | 1 | External overhead bit |
| ais_req | input | 1 | Alarm-indication (all-ones) request |
| clk_lost | input | 1 | Loss-of-transmit-clock status |
| clk_lost_switch | input | 1 | Policy: raise all-ones on clock loss |
| ua1_req | input | 1 | Unframed all-ones request |
| line_bit | output | 1 | Registered bit toward the line encoder |
| pay_take | output | 1 | Current slot consumes a payload bit |

## Verification
line_bit is due exactly one rising edge after the inputs that produce it. The bench therefore drives every input on a falling edge, computes the expected bit at that moment, and compares it at the next falling edge, after the single register has loaded. pay_take has no register on its path, so it is compared one time unit after the inputs settle, within the same cycle. One directed case looks at line_bit just before the edge, to confirm that the new bit has not yet appeared.

// File: rtl/t3s_pkg.sv
package t3s_pkg;

  // test_mode encoding: bit 1 selects unframed pattern, else bit 0 framed
  localparam int TM_W = 2;

  function automatic logic payload_pick(input logic pay, input logic rx,
                                        input logic pat, input logic plb,
                                        input logic pat_framed);
    if (pat_framed) return pat;
    if (plb)        return rx;
    return pay;
  endfunction

  function automatic logic slot_pick(input logic ovh, input logic pt,
                                     input logic fmt, input logic payv);
    return (ovh && !pt) ? fmt : payv;
  endfunction

endpackage

// File: rtl/t3s_src_mux.sv
module t3s_src_mux
  import t3s_pkg::*;
(
  input  logic            pay_bit,
  input  logic            rx_bit,
  input  logic            pat_bit,
  input  logic            fmt_bit,
  input  logic            ovh_slot,
  input  logic            loop_pay,
  input  logic            pass_thru,
  input  logic [TM_W-1:0] test_mode,
  output logic            sel_bit,
  output logic            pat_unframed,
  output logic            pay_take
);
  logic pat_framed;
  logic payv;

  assign pat_unframed = test_mode[1];
  assign pat_framed   = !test_mode[1] && test_mode[0];
  assign payv         = payload_pick(pay_bit, rx_bit, pat_bit, loop_pay, pat_framed);

  always_comb begin
    if (pat_unframed) sel_bit = pat_bit;
    else              sel_bit = slot_pick(ovh_slot, pass_thru, fmt_bit, payv);
  end

  assign pay_take = pass_thru || !ovh_slot;
endmodule

// File: rtl/t3s_ovh_overlay.sv
module t3s_ovh_overlay (
  input  logic sel_bit,
  input  logic pat_unframed,
  input  logic toh_en,
  input  logic toh_bit,
  output logic ov_bit,
  output logic toh_applied
);
  assign toh_applied = toh_en && !pat_unframed;
  assign ov_bit      = toh_applied ? toh_bit : sel_bit;
endmodule

// File: rtl/t3s_alarm_force.sv
module t3s_alarm_force (
  input  logic ais_req,
  input  logic clk_lost,
  input  logic clk_lost_switch,
  input  logic ua1_req,
  output logic ais_on,
  output logic force_ones
);
  assign ais_on     = ais_req || (clk_lost && clk_lost_switch);
  assign force_ones = ais_on || ua1_req;
endmodule

// File: rtl/t3_tx_bit_select.sv
module t3_tx_bit_select
  import t3s_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pay_bit,
  input  logic            rx_bit,
  input  logic            pat_bit,
  input  logic            fmt_bit,
  input  logic            ovh_slot,
  input  logic            loop_pay,
  input  logic            pass_thru,
  input  logic [TM_W-1:0] test_mode,
  input  logic            toh_en,
  input  logic            toh_bit,
  input  logic            ais_req,
  input  logic            clk_lost,
  input  logic            clk_lost_switch,
  input  logic            ua1_req,
  output logic            line_bit,
  output logic            pay_take
);
  logic sel_bit, pat_unframed, ov_bit, toh_applied, ais_on, force_ones;
  logic next_bit;

  t3s_src_mux u_mux (
    .pay_bit(pay_bit), .rx_bit(rx_bit), .pat_bit(pat_bit), .fmt_bit(fmt_bit),
    .ovh_slot(ovh_slot), .loop_pay(loop_pay), .pass_thru(pass_thru),
    .test_mode(test_mode), .sel_bit(sel_bit), .pat_unframed(pat_unframed),
    .pay_take(pay_take)
  );

  t3s_ovh_overlay u_ovl (
    .sel_bit(sel_bit), .pat_unframed(pat_unframed), .toh_en(toh_en),
    .toh_bit(toh_bit), .ov_bit(ov_bit), .toh_applied(toh_applied)
  );

  t3s_alarm_force u_alm (
    .ais_req(ais_req), .clk_lost(clk_lost), .clk_lost_switch(clk_lost_switch),
    .ua1_req(ua1_req), .ais_on(ais_on), .force_ones(force_ones)
  );

  assign next_bit = force_ones ? 1'b1 : ov_bit;

  always_ff @(posedge clk) begin
    if (rst) line_bit <= 1'b0;
    else     line_bit <= next_bit;
  end

  // R1: reset wins over every request
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> !line_bit);

  // R2: registered output follows previous-cycle selection
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !force_ones |=> line_bit == $past(ov_bit));

  // R7: overwrite carries the overhead port bit
  p_toh_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (toh_applied && !force_ones) |=> line_bit == $past(toh_bit));

  // R8: unframed pattern is passed untouched
  p_unframed_r8: assert property (@(posedge clk) disable iff (rst)
    (pat_unframed && !force_ones) |=> line_bit == $past(pat_bit));

  // R9: alarm request yields ones on the line
  p_ais_ones_r9: assert property (@(posedge clk) disable iff (rst)
    ais_on |=> line_bit);

  // R10: unframed all-ones request yields ones
  p_ua1_ones_r10: assert property (@(posedge clk) disable iff (rst)
    ua1_req |=> line_bit);

  // R11: payload strobe is never low in pass-through
  p_take_pt_r11: assert property (@(posedge clk) disable iff (rst)
    pass_thru |-> pay_take);
endmodule

// File: tb/t3_tx_bit_select_tb.sv
module t3_tx_bit_select_tb_top;
  localparam int CLK_HALF = 5;

  logic clk = 1'b0;
  logic rst;
  logic pay_bit, rx_bit, pat_bit, fmt_bit, ovh_slot, loop_pay, pass_thru;
  logic [1:0] test_mode;
  logic toh_en, toh_bit, ais_req, clk_lost, clk_lost_switch, ua1_req;
  logic line_bit, pay_take;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #CLK_HALF clk = ~clk;

  t3_tx_bit_select dut_i (
    .clk(clk), .rst(rst), .pay_bit(pay_bit), .rx_bit(rx_bit), .pat_bit(pat_bit),
    .fmt_bit(fmt_bit), .ovh_slot(ovh_slot), .loop_pay(loop_pay),
    .pass_thru(pass_thru), .test_mode(test_mode), .toh_en(toh_en),
    .toh_bit(toh_bit), .ais_req(ais_req), .clk_lost(clk_lost),
    .clk_lost_switch(clk_lost_switch), .ua1_req(ua1_req),
    .line_bit(line_bit), .pay_take(pay_take)
  );

  function automatic bit model_bit();
    bit payload;
    if (ua1_req || ais_req || (clk_lost && clk_lost_switch)) return 1'b1;
    if (test_mode[1]) return pat_bit;
    if (toh_en) return toh_bit;
    case ({test_mode[0], loop_pay})
      2'b10, 2'b11: payload = pat_bit;
      2'b01:        payload = rx_bit;
      default:      payload = pay_bit;
    endcase
    if (pass_thru) return payload;
    return ovh_slot ? fmt_bit : payload;
  endfunction

  function automatic string model_tag();
    if (ua1_req) return "R10";
    if (ais_req || (clk_lost && clk_lost_switch)) return "R9";
    if (test_mode[1]) return "R8";
    if (toh_en) return "R7";
    if (pass_thru) return "R6";
    if (test_mode[0]) return "R5";
    if (loop_pay) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clear_ctl();
    loop_pay = 0; pass_thru = 0; test_mode = 2'b00; toh_en = 0; toh_bit = 0;
    ais_req = 0; clk_lost = 0; clk_lost_switch = 0; ua1_req = 0;
  endtask

  task automatic set_data(input bit pa, input bit rx, input bit pt, input bit fm, input bit ov);
    pay_bit = pa; rx_bit = rx; pat_bit = pt; fmt_bit = fm; ovh_slot = ov;
  endtask

  // inputs are already applied after a falling edge; check both outputs
  task automatic run_one(input string tag);
    bit e;
    e = model_bit();
    #1;
    check("R11", pay_take, pass_thru || !ovh_slot);
    @(negedge clk);
    check(tag, line_bit, e);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1; clear_ctl(); set_data(1, 1, 1, 1, 0);
    ua1_req = 1;
    @(negedge clk); @(negedge clk);
    check("R1", line_bit, 1'b0);
    rst = 0; clear_ctl();

    // R2: new value must not appear before the edge
    set_data(1, 0, 0, 0, 0);
    @(negedge clk);
    check("R2", line_bit, 1'b1);
    set_data(0, 1, 1, 1, 0);
    #2; check("R2", line_bit, 1'b1);
    @(negedge clk); check("R2", line_bit, 1'b0);

    // R3 overhead and payload slot
    set_data(0, 1, 1, 1, 1); run_one("R3");
    set_data(1, 0, 0, 0, 0); run_one("R3");
    // R4 loopback keeps overhead
    loop_pay = 1;
    set_data(0, 1, 0, 0, 0); run_one("R4");
    set_data(1, 1, 1, 0, 1); run_one("R4");
    // R5 framed pattern beats loopback
    test_mode = 2'b01;
    set_data(0, 0, 1, 0, 0); run_one("R5");
    set_data(1, 1, 1, 0, 1); run_one("R5");
    // R6 pass-through ignores overhead slot
    clear_ctl(); pass_thru = 1;
    set_data(1, 0, 0, 0, 1); run_one("R6");
    loop_pay = 1; set_data(0, 1, 0, 0, 1); run_one("R6");
    // R7 overwrite in pass-through
    toh_en = 1; toh_bit = 0; set_data(1, 1, 1, 1, 1); run_one("R7");
    toh_bit = 1; set_data(0, 0, 0, 0, 0); run_one("R7");
    // R8 unframed pattern ignores overwrite
    test_mode = 2'b10; toh_bit = 1; set_data(1, 1, 0, 1, 1); run_one("R8");
    test_mode = 2'b11; toh_bit = 0; set_data(0, 0, 1, 0, 0); run_one("R8");
    // R9 clock loss gated by policy
    clear_ctl(); clk_lost = 1; set_data(0, 0, 0, 0, 0); run_one("R9");
    clk_lost_switch = 1; run_one("R9");
    clear_ctl(); ais_req = 1; toh_en = 1; run_one("R9");
    // R10 over unframed pattern
    clear_ctl(); ua1_req = 1; test_mode = 2'b10; set_data(0, 0, 0, 0, 0); run_one("R10");

    for (int i = 0; i < 600; i++) begin
      set_data($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), $urandom_range(0, 1));
      loop_pay = $urandom_range(0, 1); pass_thru = $urandom_range(0, 1);
      test_mode = 2'($urandom_range(0, 3)); toh_en = ($urandom_range(0, 3) == 0);
      toh_bit = $urandom_range(0, 1); ais_req = ($urandom_range(0, 7) == 0);
      clk_lost = $urandom_range(0, 1); clk_lost_switch = ($urandom_range(0, 3) == 0);
      ua1_req = ($urandom_range(0, 9) == 0);
      run_one(model_tag());
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule